// File: doc/BRIEF.md
# Microprogram Next-Address Sequencer

This block chooses the address of the next microinstruction in a microcoded controller. It keeps a micro-program counter that drives the address input of a control store. The microinstruction being executed carries a 2-bit next-address code. The decoder of the surrounding machine supplies the opcode of the current instruction. On every clock edge the counter takes one of three values: zero, the current value plus one, or an entry looked up from a fixed dispatch table that is keyed by the opcode.

A typical microprogram fetches at address 0000 and steps to 0001. There it decodes and dispatches to the first microinstruction of one of five instruction classes. Each class routine ends by returning to zero. If the opcode has no entry in the table, the counter falls back to zero and a one-cycle flag reports the unknown instruction. The counter width and the opcode width are parameters, and elaboration checks their lower bounds. The dispatch entries themselves are fixed.

Top module: `useq_next_addr`

## Requirements
- R1: A synchronous active-high `rst` sampled at a clock edge makes `uaddr` 0000 and `illegal_op` 0 after that edge, whatever the other inputs are.
- R2: With `addr_ctl` = 00 at a clock edge, `uaddr` becomes 0000 after the edge.
- R3: With `addr_ctl` = 10 at a clock edge, `uaddr` becomes its previous value plus one.
- R4: The step of R3 wraps, so 1111 plus one gives 0000.
- R5: With `addr_ctl` = 01, `uaddr` takes the dispatch entry for `opcode`: 000000 gives 0100, 000100 gives 0011, 001101 gives 0110, 100011 gives 1000 and 101011 gives 1011. `illegal_op` stays 0.
- R6: With `addr_ctl` = 01 and any other opcode, `uaddr` becomes 0000 and `illegal_op` is 1 for exactly the following cycle. A second such dispatch keeps it high for one more cycle.
- R7: The reserved code `addr_ctl` = 11 behaves exactly like 00 and never raises `illegal_op`.
- R8: `opcode` has no effect when `addr_ctl` is not 01: `uaddr` follows R2, R3 or R7 for every opcode, and `illegal_op` stays 0.
- R9: From reset, a fetch step (10) followed by a decode dispatch (01) at 0001 reaches the class entry two cycles after reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| addr_ctl | input | 2 | Next-address code of the current microinstruction |
| opcode | input | 6 | Opcode of the instruction being decoded |
| uaddr | output | 4 | Current micro-address, drives the control store |
| illegal_op | output | 1 | One-cycle flag after a dispatch on an unknown opcode |

## Verification
The checker assumes that `addr_ctl` and `opcode` hold known values at every edge. It also assumes that reset is asserted from the first edge, so `$past` never reaches back before a defined state. The bench changes inputs only on falling edges, always drives all four `addr_ctl` codes with defined opcodes, and starts with reset held for two cycles. All 64 opcode values pass through a dispatch at 0001. The counter steps through all sixteen addresses, including the wrap.

// File: rtl/useq_pkg.sv
package useq_pkg;

   typedef enum logic [1:0] {
      ACTL_ZERO     = 2'b00,
      ACTL_DISPATCH = 2'b01,
      ACTL_STEP     = 2'b10,
      ACTL_RSVD     = 2'b11
   } actl_e;

   localparam int unsigned DISP_ENTRIES  = 5;
   localparam int unsigned DISP_OPC_BITS = 6;
   localparam int unsigned DISP_TGT_BITS = 4;

   // opcode key of dispatch entry idx
   function automatic logic [DISP_OPC_BITS-1:0] disp_opcode(input int unsigned idx);
      case (idx)
         0:       disp_opcode = 6'b000000;  // register-register
         1:       disp_opcode = 6'b000100;  // branch on equal
         2:       disp_opcode = 6'b001101;  // or immediate
         3:       disp_opcode = 6'b100011;  // load word
         default: disp_opcode = 6'b101011;  // store word
      endcase
   endfunction

   // micro-address of dispatch entry idx
   function automatic logic [DISP_TGT_BITS-1:0] disp_target(input int unsigned idx);
      case (idx)
         0:       disp_target = 4'b0100;
         1:       disp_target = 4'b0011;
         2:       disp_target = 4'b0110;
         3:       disp_target = 4'b1000;
         default: disp_target = 4'b1011;
      endcase
   endfunction

endpackage

// File: rtl/useq_dispatch.sv
module useq_dispatch #(
   parameter int unsigned OPC_W = 6,
   parameter int unsigned UPC_W = 4,
   parameter int unsigned N_ENT = useq_pkg::DISP_ENTRIES
) (
   input  logic [OPC_W-1:0] opcode,
   output logic [UPC_W-1:0] target,
   output logic             hit
);
   import useq_pkg::*;

   if (OPC_W < DISP_OPC_BITS) begin : g_bad_opc
      $error("useq_dispatch: OPC_W below dispatch key width");
   end
   if (UPC_W < DISP_TGT_BITS) begin : g_bad_upc
      $error("useq_dispatch: UPC_W below dispatch target width");
   end
   if (N_ENT < 1 || N_ENT > DISP_ENTRIES) begin : g_bad_ent
      $error("useq_dispatch: N_ENT out of range");
   end

   logic [N_ENT-1:0] match;
   logic [UPC_W-1:0] tgt_masked [N_ENT];

   for (genvar gi = 0; gi < N_ENT; gi++) begin : g_entry
      assign match[gi]      = (opcode == OPC_W'(disp_opcode(gi)));
      assign tgt_masked[gi] = match[gi] ? UPC_W'(disp_target(gi)) : '0;
   end

   always_comb begin
      target = '0;
      for (int i = 0; i < int'(N_ENT); i++) begin
         target = target | tgt_masked[i];
      end
   end

   assign hit = |match;

endmodule

// File: rtl/useq_incr.sv
module useq_incr #(
   parameter int unsigned UPC_W = 4
) (
   input  logic [UPC_W-1:0] cur,
   output logic [UPC_W-1:0] nxt
);
   if (UPC_W < 1) begin : g_bad_w
      $error("useq_incr: UPC_W must be positive");
   end

   // carry out dropped: the top address wraps to zero
   assign nxt = cur + UPC_W'(1);

endmodule

// File: rtl/useq_next_sel.sv
module useq_next_sel #(
   parameter int unsigned UPC_W = 4
) (
   input  logic [1:0]       ctl,
   input  logic [UPC_W-1:0] step_addr,
   input  logic [UPC_W-1:0] disp_addr,
   input  logic             disp_hit,
   output logic [UPC_W-1:0] next_addr,
   output logic             bad_dispatch
);
   import useq_pkg::*;

   actl_e sel;
   assign sel = actl_e'(ctl);

   always_comb begin
      next_addr    = '0;
      bad_dispatch = 1'b0;
      case (sel)
         ACTL_STEP: next_addr = step_addr;
         ACTL_DISPATCH: begin
            if (disp_hit) begin
               next_addr = disp_addr;
            end else begin
               bad_dispatch = 1'b1;
            end
         end
         default: next_addr = '0;  // zero and reserved
      endcase
   end

endmodule

// File: rtl/useq_next_addr.sv
module useq_next_addr #(
   parameter int unsigned UPC_W = 4,
   parameter int unsigned OPC_W = 6
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [1:0]       addr_ctl,
   input  logic [OPC_W-1:0] opcode,
   output logic [UPC_W-1:0] uaddr,
   output logic             illegal_op
);
   logic [UPC_W-1:0] upc_q;
   logic             ill_q;
   logic [UPC_W-1:0] step_addr;
   logic [UPC_W-1:0] disp_addr;
   logic             disp_hit;
   logic [UPC_W-1:0] next_addr;
   logic             bad_dispatch;

   useq_incr #(.UPC_W(UPC_W)) u_incr (
      .cur (upc_q),
      .nxt (step_addr)
   );

   useq_dispatch #(.OPC_W(OPC_W), .UPC_W(UPC_W)) u_disp (
      .opcode (opcode),
      .target (disp_addr),
      .hit    (disp_hit)
   );

   useq_next_sel #(.UPC_W(UPC_W)) u_sel (
      .ctl          (addr_ctl),
      .step_addr    (step_addr),
      .disp_addr    (disp_addr),
      .disp_hit     (disp_hit),
      .next_addr    (next_addr),
      .bad_dispatch (bad_dispatch)
   );

   always_ff @(posedge clk) begin
      if (rst) begin
         upc_q <= '0;
         ill_q <= 1'b0;
      end else begin
         upc_q <= next_addr;
         ill_q <= bad_dispatch;
      end
   end

   assign uaddr      = upc_q;
   assign illegal_op = ill_q;

endmodule

// File: rtl/useq_next_addr_chk.sv
module useq_next_addr_chk #(
   parameter int unsigned UPC_W = 4,
   parameter int unsigned OPC_W = 6
) (
   input logic             clk,
   input logic             rst,
   input logic [1:0]       addr_ctl,
   input logic [OPC_W-1:0] opcode,
   input logic [UPC_W-1:0] uaddr,
   input logic             illegal_op
);
   a_r1_reset: assert property (@(posedge clk)
      rst |=> (uaddr == '0) && !illegal_op);

   a_r2_zero: assert property (@(posedge clk) disable iff (rst)
      (addr_ctl == 2'b00) |=> (uaddr == '0));

   a_r3_step: assert property (@(posedge clk) disable iff (rst)
      (addr_ctl == 2'b10) |=> (uaddr == UPC_W'($past(uaddr) + 1'b1)));

   a_r4_wrap: assert property (@(posedge clk) disable iff (rst)
      (addr_ctl == 2'b10) && (&uaddr) |=> (uaddr == '0));

   a_r5_load_entry: assert property (@(posedge clk) disable iff (rst)
      (addr_ctl == 2'b01) && (opcode == OPC_W'(6'b100011)) |=> (uaddr == UPC_W'(4'b1000)) && !illegal_op);

   // every legal target is nonzero, so exactly one outcome holds after a dispatch
   a_r6_dispatch_outcome: assert property (@(posedge clk) disable iff (rst)
      (addr_ctl == 2'b01) |=> ((uaddr != '0) != illegal_op));

   a_r6_flag_at_zero: assert property (@(posedge clk) disable iff (rst)
      illegal_op |-> (uaddr == '0) && ($past(addr_ctl) == 2'b01));

   a_r7_reserved: assert property (@(posedge clk) disable iff (rst)
      (addr_ctl == 2'b11) |=> (uaddr == '0) && !illegal_op);

   a_r8_no_flag: assert property (@(posedge clk) disable iff (rst)
      (addr_ctl != 2'b01) |=> !illegal_op);

endmodule

bind useq_next_addr useq_next_addr_chk #(.UPC_W(UPC_W), .OPC_W(OPC_W)) u_chk (.*);

// File: tb/test_useq_next_addr.sv
module test_useq_next_addr;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic [1:0] addr_ctl = 2'b00;
   logic [5:0] opcode = 6'b000000;
   logic [3:0] uaddr;
   logic       illegal_op;

   int errors = 0;
   int checks = 0;
   logic [3:0] exp_addr = 4'd0;
   logic       exp_ill  = 1'b0;

   always #2 clk = ~clk;  // 250 MHz

   useq_next_addr i_useq_next_addr (
      .clk        (clk),
      .rst        (rst),
      .addr_ctl   (addr_ctl),
      .opcode     (opcode),
      .uaddr      (uaddr),
      .illegal_op (illegal_op)
   );

   // dispatch table from R5
   function automatic logic [4:0] lookup(input logic [5:0] o);
      case (o)
         6'b000000: lookup = {1'b1, 4'b0100};
         6'b000100: lookup = {1'b1, 4'b0011};
         6'b001101: lookup = {1'b1, 4'b0110};
         6'b100011: lookup = {1'b1, 4'b1000};
         6'b101011: lookup = {1'b1, 4'b1011};
         default:   lookup = 5'b0;
      endcase
   endfunction

   task automatic check(input string req, input logic [3:0] a, input logic f);
      checks++;
      if (uaddr !== a || illegal_op !== f) begin
         errors++;
         $display("FAIL %s: uaddr=%b illegal_op=%b expected uaddr=%b illegal_op=%b",
                  req, uaddr, illegal_op, a, f);
      end
   endtask

   task automatic step(input logic r, input logic [1:0] c, input logic [5:0] o, input string req);
      logic [4:0] lk;
      @(negedge clk);
      rst = r; addr_ctl = c; opcode = o;
      @(posedge clk);
      exp_ill = 1'b0;
      if (r) begin
         exp_addr = 4'd0;
      end else begin
         case (c)
            2'b10: exp_addr = exp_addr + 4'd1;
            2'b01: begin
               lk = lookup(o);
               exp_addr = lk[3:0];
               exp_ill  = ~lk[4];
            end
            default: exp_addr = 4'd0;
         endcase
      end
      #1 check(req, exp_addr, exp_ill);
   endtask

   initial begin
      #(4 * 200000);
      errors++;
      $display("FAIL watchdog: run did not complete");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      @(posedge clk);
      @(posedge clk);
      #1 check("R1 reset state", 4'd0, 1'b0);

      // R9: fetch, step to decode, dispatch a load
      step(1'b0, 2'b10, 6'b100011, "R9 fetch step");
      step(1'b0, 2'b01, 6'b100011, "R9 decode dispatch");

      // R5 / R6: every opcode dispatched from 0001
      for (int op = 0; op < 64; op++) begin
         step(1'b0, 2'b00, 6'(op), "R2 return to fetch");
         step(1'b0, 2'b10, 6'(op), "R3 fetch to decode");
         step(1'b0, 2'b01, 6'(op), lookup(6'(op)) [4] ? "R5 dispatch entry" : "R6 unknown opcode");
         step(1'b0, 2'b00, 6'(op), "R6 flag one cycle");
      end

      // R6: two unknown dispatches in a row
      step(1'b0, 2'b01, 6'b111111, "R6 first unknown");
      step(1'b0, 2'b01, 6'b010101, "R6 second unknown");
      step(1'b0, 2'b10, 6'b010101, "R6 flag clears");

      // R3 / R4 / R7: walk all addresses, reserved code from each
      for (int a = 0; a < 16; a++) begin
         step(1'b0, 2'b00, 6'b000000, "R2 zero");
         for (int k = 0; k < a; k++) step(1'b0, 2'b10, 6'(k * 5), "R3 step");
         step(1'b0, 2'b11, 6'b100011, "R7 reserved acts as zero");
      end
      step(1'b0, 2'b00, 6'b0, "R2 zero");
      for (int k = 0; k < 15; k++) step(1'b0, 2'b10, 6'b0, "R3 step");
      step(1'b0, 2'b10, 6'b101011, "R4 wrap to zero");

      // R8: opcode ignored for codes other than 01
      for (int op = 0; op < 64; op += 7) begin
         step(1'b0, 2'b10, 6'(op), "R8 step ignores opcode");
         step(1'b0, 2'b11, 6'(op), "R8 reserved ignores opcode");
         step(1'b0, 2'b10, 6'(op), "R8 step ignores opcode");
         step(1'b0, 2'b00, 6'(op), "R8 zero ignores opcode");
      end

      // R1: reset mid-run overrides a step and a pending flag
      step(1'b0, 2'b10, 6'b0, "R3 step");
      step(1'b0, 2'b10, 6'b0, "R3 step");
      step(1'b1, 2'b10, 6'b0, "R1 reset overrides step");
      step(1'b0, 2'b10, 6'b0, "R3 step");
      step(1'b1, 2'b01, 6'b110000, "R1 reset overrides unknown dispatch");

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule